// File: doc/BRIEF.md
# Synchronous Serial Port, SPI Master

This block is a register-mapped serial port that drives one SPI bus as master. Software or a bus agent writes words into an eight-entry transmit queue. The block shifts each word out on the data output and captures the same number of bits from the data input into an eight-entry receive queue. The agent then reads the captured words back through the same data register.

The word length can be set from 4 to 16 bits. Clock polarity and phase can be set to any of the four SPI modes. The bit rate comes from two dividers in series. The first is an even prescaler. The second divides the result by one plus a rate value.

An active-low frame output marks the shifting period. A single interrupt line combines three enabled causes: the receive queue reaching half full, the transmit queue falling to half empty, and a latched receive overrun. A loopback switch routes the data output back to the capture path, which lets the port test itself without a slave.

Top module: `ssp_spi_master`

## Requirements
- R1: Registers are addressed by byte offset: 0x00 format (bits 3:0 size code, bit 6 phase, bit 7 polarity, bits 15:8 rate value), 0x04 control (bit 0 receive-level enable, bit 1 transmit-level enable, bit 2 overrun enable, bit 3 loopback, bit 4 port enable, bits 6:5 stored only), 0x08 data, 0x0C status, 0x10 prescaler, 0x14 interrupt cause. The format, control and prescaler registers read back what was written, except that prescaler bit 0 always reads 0. All registers reset to 0.
- R2: A frame carries size code + 1 bits, most significant bit first. Size codes 0 to 2 give 4-bit frames. While a frame runs, the clock idles at the polarity level. The slave samples on the edge where the clock goes to the level equal to (polarity XNOR phase) high. When phase is 1, the first clock edge comes at the start of the frame.
- R3: Each half of a bit period lasts (P/2)·(rate value + 1) clock cycles, where P is the stored prescaler. A stored prescaler below 2 acts as 2.
- R4: Writing the data register pushes into the transmit queue, which holds 8 words. A write while the queue is full is dropped. Status reads bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, bit 4 busy. After reset, status reads 0x03.
- R5: Reading the data register pops one received word, right-justified and zero-extended to 16 bits. A read while the receive queue is empty returns 0 and changes nothing.
- R6: If a frame completes while the receive queue is full, the word is discarded and an overrun flag is set. The flag persists until any write to offset 0x14. It shows in interrupt cause bit 2 when overrun enable is set.
- R7: Interrupt cause bit 0 is 1 when the receive level enable is set and the receive queue holds 4 or more words. Cause bit 1 is 1 when the transmit level enable is set and the transmit queue holds 4 or fewer words. The interrupt output is the OR of the three cause bits.
- R8: While port enable is 0, nothing shifts. The frame output stays high and the clock stays at the polarity level, while queued transmit words are kept.
- R9: With loopback set, the capture path takes the data output and ignores the data input pin.
- R10: Busy is 1 while a frame runs or the transmit queue is not empty. Queued words go out back to back with the frame output held low across them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops the receive queue at 0x08) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the address |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| frame_n_o | output | 1 | Low while a frame shifts |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a receive overrun. The receive queue must be completely full at the moment a further frame ends, and the agent must not have drained it. The bench first loops eight frames back while leaving the queue unread, then queues a ninth word. It then checks that the flag is set and stays set, and that only the first eight words can be read back. A related corner, a ninth transmit write that is silently dropped, is reached by filling the queue with the port disabled.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_FMT  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_PRE  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 5'h14;

    typedef struct packed {
        logic [7:0] rate;
        logic       cpol;
        logic       cpha;
        logic [1:0] spare;
        logic [3:0] size;
    } fmt_t;

    typedef struct packed {
        logic spare_b;
        logic spare_a;
        logic en;
        logic loop;
        logic ovr_ie;
        logic tx_ie;
        logic rx_ie;
    } ctl_t;

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               wp;
        logic [PW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    always_comb begin
        f_d     = f_q;
        do_push = push && (f_q.cnt != CAP);
        do_pop  = pop && (f_q.cnt != '0);
        if (do_push) begin
            f_d.mem[f_q.wp] = din;
            f_d.wp = (f_q.wp == LAST) ? '0 : f_q.wp + PW'(1);
        end
        if (do_pop) begin
            f_d.rp = (f_q.rp == LAST) ? '0 : f_q.rp + PW'(1);
        end
        if (do_push && !do_pop) begin
            f_d.cnt = f_q.cnt + CW'(1);
        end else if (do_pop && !do_push) begin
            f_d.cnt = f_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign dout  = f_q.mem[f_q.rp];
    assign count = f_q.cnt;
    assign full  = (f_q.cnt == CAP);
    assign empty = (f_q.cnt == '0);

endmodule

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half_len,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t d_d, d_q;

    always_comb begin
        d_d  = d_q;
        tick = run && (d_q.cnt == half_len - CNT_W'(1));
        if (!run || tick) d_d.cnt = '0;
        else              d_d.cnt = d_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int unsigned DW = 16,
    localparam int unsigned BW  = $clog2(DW + 1),
    localparam int unsigned PHW = $clog2(2 * DW),
    localparam int unsigned IW  = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [3:0]    size,
    input  logic          tick,
    input  logic          tx_avail,
    input  logic [DW-1:0] tx_word,
    input  logic          din,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [DW-1:0] rx_word,
    output logic          active,
    output logic          sclk,
    output logic          dout
);
    localparam int unsigned MIN_BITS = 4;

    typedef struct packed {
        logic           run;
        logic [PHW-1:0] ph;
        logic [BW-1:0]  bits;
        logic [DW-1:0]  tx_sh;
        logic [DW-1:0]  rx_sh;
    } sh_t;

    sh_t s_d, s_q;
    logic [BW-1:0]  bits_req;
    logic [PHW-1:0] last_ph;
    logic [IW-1:0]  msb;

    always_comb begin
        bits_req = (size < 4'd3) ? BW'(MIN_BITS) : BW'(size) + BW'(1);
        last_ph  = PHW'(2 * int'(s_q.bits) - 1);
        s_d      = s_q;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        if (!en) begin
            s_d.run = 1'b0;
        end else if (!s_q.run) begin
            if (tx_avail) begin
                tx_pop    = 1'b1;
                s_d.run   = 1'b1;
                s_d.ph    = '0;
                s_d.bits  = bits_req;
                s_d.tx_sh = tx_word;
                s_d.rx_sh = '0;
            end
        end else if (tick) begin
            if (!s_q.ph[0]) s_d.rx_sh = {s_q.rx_sh[DW-2:0], din};
            if (s_q.ph == last_ph) begin
                rx_push = 1'b1;
                if (tx_avail) begin
                    tx_pop    = 1'b1;
                    s_d.ph    = '0;
                    s_d.bits  = bits_req;
                    s_d.tx_sh = tx_word;
                    s_d.rx_sh = '0;
                end else begin
                    s_d.run = 1'b0;
                end
            end else begin
                if (s_q.ph[0]) s_d.tx_sh = {s_q.tx_sh[DW-2:0], 1'b0};
                s_d.ph = s_q.ph + PHW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign msb     = IW'(s_q.bits - BW'(1));
    assign rx_word = s_q.rx_sh;
    assign active  = s_q.run;
    assign sclk    = s_q.run ? (cpol ^ cpha ^ s_q.ph[0]) : cpol;
    assign dout    = s_q.run & s_q.tx_sh[msb];

endmodule

// File: rtl/ssp_spi_master.sv
module ssp_spi_master
    import ssp_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned DIV_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              frame_n_o,
    output logic              irq_o
);
    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(FIFO_DEPTH / 2);

    typedef struct packed {
        fmt_t       fmt;
        ctl_t       ctl;
        logic [7:0] pre;
        logic       ovr;
    } regs_t;

    regs_t r_d, r_q;

    logic [DATA_W-1:0] tx_head, rx_head, rx_word;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_push, tx_pop, rx_push_req, rx_push, rx_pop;
    logic tick, active, serial_in, dout, busy;
    logic [DIV_W-1:0] half_len;
    logic [6:0] pre_half;
    logic [2:0] cause;
    logic cfg_cpol, port_en, clr_wr, empty_rd;

    assign tx_push  = bus_we && (bus_addr == OFS_DATA) && !tx_full;
    assign rx_pop   = bus_re && (bus_addr == OFS_DATA) && !rx_empty;
    assign rx_push  = rx_push_req && !rx_full;
    assign clr_wr   = bus_we && (bus_addr == OFS_CAUSE);
    assign empty_rd = bus_re && (bus_addr == OFS_DATA) && rx_empty;
    assign cfg_cpol = r_q.fmt.cpol;
    assign port_en  = r_q.ctl.en;

    ssp_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata),
        .pop(tx_pop), .dout(tx_head), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty)
    );

    ssp_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
        .pop(rx_pop), .dout(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty)
    );

    always_comb begin
        pre_half = (r_q.pre < 8'd2) ? 7'd1 : r_q.pre[7:1];
        half_len = DIV_W'(pre_half) * (DIV_W'(r_q.fmt.rate) + DIV_W'(1));
    end

    ssp_clkdiv #(.CNT_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(active),
        .half_len(half_len), .tick(tick)
    );

    assign serial_in = r_q.ctl.loop ? dout : miso_i;

    ssp_shifter #(.DW(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(r_q.ctl.en),
        .cpol(r_q.fmt.cpol), .cpha(r_q.fmt.cpha), .size(r_q.fmt.size),
        .tick(tick), .tx_avail(!tx_empty), .tx_word(tx_head),
        .din(serial_in), .tx_pop(tx_pop), .rx_push(rx_push_req),
        .rx_word(rx_word), .active(active), .sclk(sclk_o), .dout(dout)
    );

    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            case (bus_addr)
                OFS_FMT:   r_d.fmt = fmt_t'(bus_wdata);
                OFS_CTL:   r_d.ctl = ctl_t'(bus_wdata[6:0]);
                OFS_PRE:   r_d.pre = {bus_wdata[7:1], 1'b0};
                OFS_CAUSE: r_d.ovr = 1'b0;
                default:   ;
            endcase
        end
        if (rx_push_req && rx_full) r_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        busy     = active || !tx_empty;
        cause[0] = r_q.ctl.rx_ie && (rx_cnt >= HALF);
        cause[1] = r_q.ctl.tx_ie && (tx_cnt <= HALF);
        cause[2] = r_q.ctl.ovr_ie && r_q.ovr;
        case (bus_addr)
            OFS_FMT:   bus_rdata = r_q.fmt;
            OFS_CTL:   bus_rdata = {9'b0, r_q.ctl};
            OFS_DATA:  bus_rdata = rx_empty ? '0 : rx_head;
            OFS_STAT:  bus_rdata = {11'b0, busy, rx_full, !rx_empty, !tx_full, tx_empty};
            OFS_PRE:   bus_rdata = {8'b0, r_q.pre};
            OFS_CAUSE: bus_rdata = {13'b0, cause};
            default:   bus_rdata = '0;
        endcase
    end

    assign mosi_o    = dout;
    assign frame_n_o = !active;
    assign irq_o     = |cause;

endmodule

// File: rtl/ssp_spi_master_chk.sv
module ssp_spi_master_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sclk_o,
    input logic          frame_n_o,
    input logic          cpol,
    input logic          port_en,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic          ovr,
    input logic          clr_wr,
    input logic          empty_rd,
    input logic [15:0]   rdata
);
    a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n_o |-> (sclk_o == cpol));

    a_r8_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> frame_n_o);

    a_r4_queue_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_cnt) <= DEPTH) && (int'(rx_cnt) <= DEPTH));

    a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr_wr) |=> ovr);

    a_r10_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n_o) |-> ($past(tx_cnt) != '0));

    a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        empty_rd |-> (rdata == 16'h0000));
endmodule

bind ssp_spi_master ssp_spi_master_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk_o(sclk_o), .frame_n_o(frame_n_o),
    .cpol(cfg_cpol), .port_en(port_en), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .ovr(r_q.ovr), .clr_wr(clr_wr), .empty_rd(empty_rd), .rdata(bus_rdata)
);

// File: tb/test_ssp_spi_master.sv
module test_ssp_spi_master;
    localparam int LIMIT = 150000;
    localparam logic [4:0] A_FMT = 5'h00, A_CTL = 5'h04, A_DAT = 5'h08,
                           A_STA = 5'h0C, A_PRE = 5'h10, A_CAU = 5'h14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0, bus_re = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic sclk_o, mosi_o, miso_i, frame_n_o, irq_o;

    int ncmp = 0, nbad = 0, cyc = 0;
    int sl_bits = 8, sl_cnt = 0, sl_idx = 0, sl_cap = 0;
    int got [0:15];
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic sl_prev = 1'b0, fn_prev = 1'b1;
    int frame_ends = 0, n_edges = 0;
    int edge_t [0:3];

    always #10 clk = ~clk;

    ssp_spi_master i_ssp_spi_master (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i),
        .frame_n_o(frame_n_o), .irq_o(irq_o)
    );

    function automatic int resp_of(int i);
        return (32'hC3A5 + i * 32'h2F1D) & 32'hFFFF;
    endfunction
    function automatic int tx_of(int i, int salt);
        return (32'h5B27 + i * 32'h4C93 + salt * 32'h0711) & 32'hFFFF;
    endfunction
    function automatic int mask_of(int w);
        return (1 << w) - 1;
    endfunction
    function automatic logic slave_bit(int i, int c, int b);
        int r = resp_of(i);
        if (c < b) return r[b - 1 - c];
        return 1'b0;
    endfunction

    assign miso_i = slave_bit(sl_idx, sl_cnt, sl_bits);

    always @(posedge clk) cyc <= cyc + 1;

    // slave model: samples mosi and advances its own bit on the sample edge
    always @(negedge clk) begin
        if (sclk_o != sl_prev) begin
            if (n_edges < 4) begin
                edge_t[n_edges] = cyc;
                n_edges = n_edges + 1;
            end
            if (!frame_n_o && (sclk_o == (cfg_cpol == cfg_cpha))) begin
                sl_cap = (sl_cap << 1) | int'(mosi_o);
                sl_cnt = sl_cnt + 1;
                if (sl_cnt == sl_bits) begin
                    if (sl_idx < 16) got[sl_idx] = sl_cap & mask_of(sl_bits);
                    sl_idx = sl_idx + 1;
                    sl_cnt = 0;
                    sl_cap = 0;
                end
            end
        end
        if (frame_n_o && !fn_prev) frame_ends = frame_ends + 1;
        sl_prev = sclk_o;
        fn_prev = frame_n_o;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    endtask

    always @(posedge clk) begin
        if (cyc == LIMIT) begin
            nbad = nbad + 1;
            $display("FAIL watchdog: run did not end, act %0d cycles exp < %0d", cyc, LIMIT);
            summary();
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        ncmp = ncmp + 1;
        if (act != exp) begin
            nbad = nbad + 1;
            $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = 16'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output int d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wait_idle();
        int s;
        for (int k = 0; k < 4000; k++) begin
            rd(A_STA, s);
            if (s[4] == 1'b0) break;
        end
    endtask

    task automatic slave_reset(int w);
        sl_bits = w; sl_cnt = 0; sl_idx = 0; sl_cap = 0;
        for (int k = 0; k < 16; k++) got[k] = -1;
    endtask

    initial begin
        int v, w, mode;
        int widths [4] = '{4, 7, 11, 16};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // reset state
        rd(A_STA, v); check("R4 reset status", v, 32'h03);
        rd(A_FMT, v); check("R1 reset format", v, 0);
        rd(A_CTL, v); check("R1 reset control", v, 0);
        rd(A_PRE, v); check("R1 reset prescaler", v, 0);
        rd(A_CAU, v); check("R7 reset cause", v, 0);
        check("R8 reset frame", int'(frame_n_o), 1);
        check("R2 reset clock", int'(sclk_o), 0);
        check("R7 reset irq", int'(irq_o), 0);

        // R1 read-back, R3 prescaler bit 0
        wr(A_FMT, 32'hA5C7); rd(A_FMT, v); check("R1 format readback", v, 32'hA5C7);
        wr(A_CTL, 32'h0067); rd(A_CTL, v); check("R1 control readback", v, 32'h67);
        wr(A_PRE, 32'h00FF); rd(A_PRE, v); check("R1 R3 prescaler even", v, 32'hFE);
        wr(A_CTL, 0);
        rd(A_DAT, v); check("R5 empty read", v, 0);

        // R2 R10: sweep modes and widths against the external slave model
        for (int m = 0; m < 4; m++) begin
            for (int wi = 0; wi < 4; wi++) begin
                w = widths[wi];
                mode = m;
                cfg_cpol = m[1]; cfg_cpha = m[0];
                wr(A_CTL, 0);
                wr(A_PRE, 2 + 2 * (wi & 1));
                wr(A_FMT, (m << 8) | (mode << 6) | (w - 1));
                repeat (2) @(negedge clk);
                slave_reset(w);
                frame_ends = 0;
                wr(A_CTL, 32'h10);
                for (int i = 0; i < 3; i++) wr(A_DAT, tx_of(i, m * 16 + w));
                wait_idle();
                repeat (2) @(negedge clk);
                for (int i = 0; i < 3; i++)
                    check($sformatf("R2 mode %0d width %0d sent word %0d", m, w, i),
                          got[i], tx_of(i, m * 16 + w) & mask_of(w));
                for (int i = 0; i < 3; i++) begin
                    rd(A_DAT, v);
                    check($sformatf("R5 R2 mode %0d width %0d received word %0d", m, w, i),
                          v, resp_of(i) & mask_of(w));
                end
                check($sformatf("R10 back to back mode %0d width %0d", m, w), frame_ends, 1);
                check($sformatf("R2 idle level mode %0d", m), int'(sclk_o), int'(m[1]));
            end
        end

        // R3: half-bit length from prescaler 7 (stored 6) and rate 3 -> 12 cycles
        cfg_cpol = 0; cfg_cpha = 0;
        wr(A_CTL, 0); wr(A_PRE, 7); wr(A_FMT, (3 << 8) | 7);
        repeat (2) @(negedge clk);
        slave_reset(8); n_edges = 0;
        wr(A_CTL, 32'h10); wr(A_DAT, 32'h5A);
        wait_idle();
        check("R3 half period 12", edge_t[2] - edge_t[1], 12);
        // prescaler 0 acts as 2 -> 4 cycles
        wr(A_CTL, 0); wr(A_PRE, 0);
        repeat (2) @(negedge clk);
        n_edges = 0;
        wr(A_CTL, 32'h10); wr(A_DAT, 32'h33);
        wait_idle();
        check("R3 half period floor", edge_t[2] - edge_t[1], 4);
        slave_reset(8);
        for (int i = 0; i < 2; i++) rd(A_DAT, v);

        // R6 R9: loopback overrun
        wr(A_CTL, 0); wr(A_PRE, 2); wr(A_FMT, 7);
        wr(A_CTL, 32'h1C);
        for (int i = 0; i < 8; i++) wr(A_DAT, tx_of(i, 99));
        wait_idle();
        rd(A_STA, v); check("R4 status receive full", v, 32'h0F);
        rd(A_CAU, v); check("R6 no overrun yet", v, 0);
        wr(A_DAT, 32'h1234);
        wait_idle();
        rd(A_CAU, v); check("R6 overrun flagged", v, 4);
        check("R7 irq on overrun", int'(irq_o), 1);
        for (int i = 0; i < 8; i++) begin
            rd(A_DAT, v); check($sformatf("R9 loopback word %0d", i), v, tx_of(i, 99) & 32'hFF);
        end
        rd(A_DAT, v); check("R6 discarded frame absent", v, 0);
        rd(A_CAU, v); check("R6 overrun sticky", v, 4);
        wr(A_CAU, 0);
        rd(A_CAU, v); check("R6 overrun cleared", v, 0);
        check("R7 irq cleared", int'(irq_o), 0);

        // R4: ninth write while disabled is dropped
        wr(A_CTL, 32'h0C);
        for (int i = 0; i < 9; i++) wr(A_DAT, tx_of(i, 7));
        rd(A_STA, v); check("R4 status transmit full", v, 32'h10);
        check("R8 no frame while disabled", int'(frame_n_o), 1);
        wr(A_CTL, 32'h1C);
        wait_idle();
        for (int i = 0; i < 8; i++) begin
            rd(A_DAT, v); check($sformatf("R4 kept word %0d", i), v, tx_of(i, 7) & 32'hFF);
        end
        rd(A_DAT, v); check("R4 dropped ninth", v, 0);
        rd(A_CAU, v); check("R4 no overrun from dropped word", v, 0);

        // R7 R8: levels, disabled with polarity 1
        wr(A_CTL, 0); wr(A_FMT, (2 << 6) | 11);
        wr(A_CTL, 32'h1B);
        rd(A_CAU, v); check("R7 transmit level cause", v, 2);
        check("R7 irq from transmit level", int'(irq_o), 1);
        wr(A_CTL, 32'h0B);
        for (int i = 0; i < 5; i++) wr(A_DAT, tx_of(i, 3));
        repeat (20) @(negedge clk);
        check("R8 clock parked at polarity", int'(sclk_o), 1);
        check("R8 frame high while disabled", int'(frame_n_o), 1);
        rd(A_STA, v); check("R8 R10 busy with queued data", v, 32'h12);
        rd(A_CAU, v); check("R7 five queued clears transmit level", v, 0);
        wr(A_CTL, 32'h1B);
        wait_idle();
        rd(A_CAU, v); check("R7 both levels", v, 3);
        rd(A_DAT, v); check("R9 12-bit loop 0", v, tx_of(0, 3) & 32'hFFF);
        rd(A_DAT, v); check("R9 12-bit loop 1", v, tx_of(1, 3) & 32'hFFF);
        rd(A_CAU, v); check("R7 receive below four", v, 2);
        for (int i = 2; i < 5; i++) begin
            rd(A_DAT, v); check($sformatf("R9 12-bit loop %0d", i), v, tx_of(i, 3) & 32'hFFF);
        end

        // R2: size code 1 gives 4-bit frames
        wr(A_CTL, 0); wr(A_FMT, 1); wr(A_CTL, 32'h18);
        wr(A_DAT, 32'hFFFF);
        wait_idle();
        rd(A_DAT, v); check("R2 short size code gives 4 bits", v, 32'h000F);

        summary();
        $finish;
    end
endmodule